// File: doc/BRIEF.md
# Parallel NOR Flash Program/Erase Sequencer

This block sits on the host side of a byte-wide parallel NOR flash bus. It takes one request at a time over a valid/ready handshake: an operation (byte program, sector erase, block erase or chip erase), a target address, a data byte and three mode flags. The flags pick the unlock-address mask, swap the two unlock addresses, and remove the pause between erase command writes. The block then drives the unlock write cycles and the command write cycles onto the flash address, data and write-strobe lines.

After the last command write, it polls the part through the read strobe until bit 6 of the read data stops toggling. A byte program then reads the target back. On a mismatch it reissues the whole command sequence, up to a bounded number of attempts. The outcome is reported on a one-cycle done pulse, with a fail flag that is valid in the same cycle.

Each bus access takes exactly one clock. Between erase command writes, and between erase poll reads, the block waits a number of idle clocks set by parameters.

Top module: `nor_cmd_seq`

## Requirements
- R1: Out of reset the block is idle: `req_ready_o` is high, and `fl_we_o`, `fl_oe_o` and `done_o` are low. A request is taken only on a clock where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` stays low from the accepting clock until the done pulse.
- R2: A byte program (`req_op_i` = 0) writes 0xAA to unlock address A, then 0x55 to unlock address B, then 0xA0 to A, then the data byte to the target address. These are four consecutive single-clock write strobes.
- R3: With `req_swap_i` low, A is 0x5555 and B is 0x2AAA. With `req_swap_i` high, A is 0x2AAA and B is 0x5555. Unlock addresses are zero-extended to the bus width.
- R4: The unlock address is ANDed with a mask chosen by `req_msel_i`: 0 gives 0xFFFF, 1 gives 0x7FF, 2 gives 0xFFF, and 3 gives 0xFFFF.
- R5: Every erase writes 0xAA@A, 0x55@B, 0x80@A, 0xAA@A, 0x55@B and then a final cycle that depends on `req_op_i`. For 1 (sector) the final cycle is 0x30 at the target. For 2 (block) it is 0x50 at the target. For 3 (chip) it is 0x10 at A.
- R6: Successive erase writes are CMD_GAP+1 clocks apart when `req_nodly_i` is low, and 1 clock apart when it is high. Program writes are always 1 clock apart.
- R7: After the last write, the block reads address 0 every poll step. Completion is the first read whose bit 6 equals bit 6 of the previous read. Erase polls are POLL_GAP+1 clocks apart and program polls are 1 clock apart.
- R8: If MAX_POLLS consecutive poll reads each differ in bit 6 from the previous read, the operation ends with fail high.
- R9: After a program completes polling, the target is read once. A match ends with fail low. A mismatch restarts from the first unlock write, and after MAX_TRIES mismatching attempts the operation ends with fail high.
- R10: A program of data 0xFF issues no bus cycle, and the done pulse with fail low follows on the clock after acceptance.
- R11: `done_o` is high for exactly one clock per request, `fail_o` is high only together with `done_o`, and the write and read strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_op_i | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr_i | input | AW | Target byte address |
| req_data_i | input | 8 | Byte to program |
| req_msel_i | input | 2 | Unlock-address mask select |
| req_swap_i | input | 1 | Swap unlock addresses A and B |
| req_nodly_i | input | 1 | No idle clocks between erase writes |
| fl_addr_o | output | AW | Flash address |
| fl_dq_o | output | 8 | Flash write data |
| fl_dq_i | input | 8 | Flash read data |
| fl_we_o | output | 1 | Write strobe, one clock per write |
| fl_oe_o | output | 1 | Read strobe, one clock per read |
| done_o | output | 1 | Operation finished, one-clock pulse |
| fail_o | output | 1 | Operation failed, valid with done_o |

## Verification
The bench targets the unlock address under every mask and swap setting. A mixed-up address would put 0xAA or 0x55 at the wrong location, and the write scoreboard would reject it.

Spacing between writes is compared with and without the no-delay flag. A design that padded program cycles, or ignored the flag, would show the wrong interval. A flash model toggles bit 6 a chosen number of times, so the bench can check the exact poll read count and the poll-limit failure. An off-by-one in the comparison would add or drop a read.

The model also returns a bad verify byte for a set number of reads. This pins the retry bound at both edges: the last allowed attempt must pass, and one more bad read must fail. A skipped 0xFF byte must produce done without a single strobe.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_SECT = 2'd1, OP_BLK = 2'd2, OP_CHIP = 2'd3} op_e;
  typedef enum logic [1:0] {AK_A, AK_B, AK_TGT} addr_kind_e;

  typedef struct packed {
    addr_kind_e kind;
    logic [7:0] data;
  } step_t;

  localparam logic [15:0] UNLOCK_LO = 16'h5555;
  localparam logic [15:0] UNLOCK_HI = 16'h2AAA;

  function automatic logic [2:0] last_step(op_e op);
    return (op == OP_PROG) ? 3'd3 : 3'd5;
  endfunction

  // program data byte is muxed in by the caller for the AK_TGT step
  function automatic step_t cmd_step(op_e op, logic [2:0] step);
    step_t s;
    s = '{kind: AK_A, data: 8'hAA};
    if (op == OP_PROG) begin
      case (step)
        3'd0:    s = '{kind: AK_A,   data: 8'hAA};
        3'd1:    s = '{kind: AK_B,   data: 8'h55};
        3'd2:    s = '{kind: AK_A,   data: 8'hA0};
        default: s = '{kind: AK_TGT, data: 8'h00};
      endcase
    end else begin
      case (step)
        3'd0:    s = '{kind: AK_A, data: 8'hAA};
        3'd1:    s = '{kind: AK_B, data: 8'h55};
        3'd2:    s = '{kind: AK_A, data: 8'h80};
        3'd3:    s = '{kind: AK_A, data: 8'hAA};
        3'd4:    s = '{kind: AK_B, data: 8'h55};
        default: begin
          case (op)
            OP_SECT: s = '{kind: AK_TGT, data: 8'h30};
            OP_BLK:  s = '{kind: AK_TGT, data: 8'h50};
            default: s = '{kind: AK_A,   data: 8'h10};
          endcase
        end
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/nor_unlock_addr.sv
module nor_unlock_addr
  import nor_seq_pkg::*;
(
  input  logic       sel_b_i,
  input  logic       swap_i,
  input  logic [1:0] msel_i,
  output logic [15:0] addr_o
);
  logic [15:0] base, mask;

  always_comb begin
    base = (sel_b_i ^ swap_i) ? UNLOCK_HI : UNLOCK_LO;
    case (msel_i)
      2'd1:    mask = 16'h07FF;
      2'd2:    mask = 16'h0FFF;
      default: mask = 16'hFFFF;
    endcase
    addr_o = base & mask;
  end
endmodule

// File: rtl/nor_tick_timer.sv
module nor_tick_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int AW        = 20,
  parameter int CMD_GAP   = 10,
  parameter int POLL_GAP  = 8,
  parameter int MAX_POLLS = 1000,
  parameter int MAX_TRIES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [7:0]    req_data_i,
  input  logic [1:0]    req_msel_i,
  input  logic          req_swap_i,
  input  logic          req_nodly_i,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_dq_o,
  input  logic [7:0]    fl_dq_i,
  output logic          fl_we_o,
  output logic          fl_oe_o,
  output logic          done_o,
  output logic          fail_o
);
  localparam int GMAX = (CMD_GAP > POLL_GAP) ? CMD_GAP : POLL_GAP;
  localparam int GW   = $clog2(GMAX + 2);
  localparam int PW   = $clog2(MAX_POLLS + 1);
  localparam int TW   = $clog2(MAX_TRIES + 1);
  localparam logic [GW-1:0] CG_LD = (CMD_GAP > 0)  ? GW'(CMD_GAP - 1)  : '0;
  localparam logic [GW-1:0] PG_LD = (POLL_GAP > 0) ? GW'(POLL_GAP - 1) : '0;

  typedef enum logic [2:0] {S_IDLE, S_WR, S_GAP, S_REF, S_PWAIT, S_POLL, S_VFY, S_DONE} st_e;

  st_e           st_q;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [1:0]    msel_q;
  logic          swap_q, nodly_q, ref_q, fail_q;
  logic [2:0]    step_q;
  logic [PW-1:0] polls_q;
  logic [TW-1:0] tries_q;

  step_t         cur;
  logic [15:0]   ua;
  logic          last, gap_en, pgap_en, poll_eq, poll_cap, tmr_zero, tmr_load;
  logic [GW-1:0] tmr_val;

  assign cur      = cmd_step(op_q, step_q);
  assign last     = (step_q == last_step(op_q));
  assign gap_en   = (op_q != OP_PROG) && !nodly_q && (CMD_GAP > 0);
  assign pgap_en  = (op_q != OP_PROG) && (POLL_GAP > 0);
  assign poll_eq  = (fl_dq_i[6] == ref_q);
  assign poll_cap = (polls_q == PW'(MAX_POLLS - 1));

  nor_unlock_addr u_ua (
    .sel_b_i (cur.kind == AK_B),
    .swap_i  (swap_q),
    .msel_i  (msel_q),
    .addr_o  (ua)
  );

  assign tmr_load = (st_q == S_WR && !last && gap_en) ||
                    (pgap_en && (st_q == S_REF || (st_q == S_POLL && !poll_eq && !poll_cap)));
  assign tmr_val  = (st_q == S_WR) ? CG_LD : PG_LD;

  nor_tick_timer #(.W(GW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      msel_q  <= '0;
      swap_q  <= 1'b0;
      nodly_q <= 1'b0;
      ref_q   <= 1'b0;
      fail_q  <= 1'b0;
      step_q  <= '0;
      polls_q <= '0;
      tries_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (req_valid_i) begin
          op_q    <= op_e'(req_op_i);
          addr_q  <= req_addr_i;
          data_q  <= req_data_i;
          msel_q  <= req_msel_i;
          swap_q  <= req_swap_i;
          nodly_q <= req_nodly_i;
          step_q  <= '0;
          tries_q <= '0;
          fail_q  <= 1'b0;
          st_q    <= (op_e'(req_op_i) == OP_PROG && req_data_i == 8'hFF) ? S_DONE : S_WR;
        end
        S_WR: begin
          if (last) st_q <= S_REF;
          else begin
            step_q <= step_q + 3'd1;
            st_q   <= gap_en ? S_GAP : S_WR;
          end
        end
        S_GAP:   if (tmr_zero) st_q <= S_WR;
        S_REF: begin
          ref_q   <= fl_dq_i[6];
          polls_q <= '0;
          st_q    <= pgap_en ? S_PWAIT : S_POLL;
        end
        S_PWAIT: if (tmr_zero) st_q <= S_POLL;
        S_POLL: begin
          if (poll_eq) st_q <= (op_q == OP_PROG) ? S_VFY : S_DONE;
          else if (poll_cap) begin
            fail_q <= 1'b1;
            st_q   <= S_DONE;
          end else begin
            ref_q   <= fl_dq_i[6];
            polls_q <= polls_q + 1'b1;
            st_q    <= pgap_en ? S_PWAIT : S_POLL;
          end
        end
        S_VFY: begin
          if (fl_dq_i == data_q) st_q <= S_DONE;
          else if (tries_q == TW'(MAX_TRIES - 1)) begin
            fail_q <= 1'b1;
            st_q   <= S_DONE;
          end else begin
            tries_q <= tries_q + 1'b1;
            step_q  <= '0;
            st_q    <= S_WR;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    fl_addr_o = '0;
    fl_dq_o   = '0;
    if (st_q == S_WR) begin
      fl_addr_o = (cur.kind == AK_TGT) ? addr_q : AW'(ua);
      fl_dq_o   = (op_q == OP_PROG && cur.kind == AK_TGT) ? data_q : cur.data;
    end else if (st_q == S_VFY) begin
      fl_addr_o = addr_q;
    end
  end

  assign fl_we_o     = (st_q == S_WR);
  assign fl_oe_o     = (st_q == S_REF) || (st_q == S_POLL) || (st_q == S_VFY);
  assign req_ready_o = (st_q == S_IDLE);
  assign done_o      = (st_q == S_DONE);
  assign fail_o      = (st_q == S_DONE) && fail_q;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic [1:0] req_op_i,
  input logic [7:0] req_data_i,
  input logic [7:0] fl_dq_o,
  input logic       fl_we_o,
  input logic       fl_oe_o,
  input logic       done_o,
  input logic       fail_o
);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_we_o && fl_oe_o));

  // R11
  fail_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o);

  // R1
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R10
  skip_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_op_i == 2'd0 && req_data_i == 8'hFF)
      |=> (done_o && !fail_o && !fl_we_o));

  // R2
  first_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !(req_op_i == 2'd0 && req_data_i == 8'hFF))
      |=> (fl_we_o && fl_dq_o == 8'hAA));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_op_i    (req_op_i),
  .req_data_i  (req_data_i),
  .fl_dq_o     (fl_dq_o),
  .fl_we_o     (fl_we_o),
  .fl_oe_o     (fl_oe_o),
  .done_o      (done_o),
  .fail_o      (fail_o)
);

// File: tb/nor_cmd_seq_tb_top.sv
module nor_cmd_seq_tb_top;
  localparam int AW        = 20;
  localparam int CMD_GAP   = 4;
  localparam int POLL_GAP  = 3;
  localparam int MAX_POLLS = 8;
  localparam int MAX_TRIES = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [1:0]    req_op = '0, req_msel = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          req_swap = 1'b0, req_nodly = 1'b0;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dq_o, fl_dq_i = '0;
  logic          fl_we, fl_oe, done, fail;

  nor_cmd_seq #(.AW(AW), .CMD_GAP(CMD_GAP), .POLL_GAP(POLL_GAP),
                .MAX_POLLS(MAX_POLLS), .MAX_TRIES(MAX_TRIES)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_data_i(req_data),
    .req_msel_i(req_msel), .req_swap_i(req_swap), .req_nodly_i(req_nodly),
    .fl_addr_o(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_i(fl_dq_i),
    .fl_we_o(fl_we), .fl_oe_o(fl_oe), .done_o(done), .fail_o(fail));

  int checks = 0, errors = 0, cyc = 0;
  int q_ivl[$];
  logic [AW-1:0] q_addr[$];
  logic [7:0]    q_data[$];
  logic          q_fail[$];
  string         q_req[$];

  // flash model
  int   tog_left = 0, bad_left = 0, poll_reads = 0, done_cnt = 0, last_we = -1;
  logic t6 = 1'b0;
  logic [7:0] cur_data = '0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ua(input bit is_b, input logic [1:0] msel, input bit swap);
    logic [15:0] b, m;
    b = (is_b ^ swap) ? 16'h2AAA : 16'h5555;
    m = (msel == 2'd1) ? 16'h07FF : (msel == 2'd2) ? 16'h0FFF : 16'hFFFF;
    return b & m;
  endfunction

  task automatic push_w(input int ivl, input logic [AW-1:0] a, input logic [7:0] d, input string req);
    q_ivl.push_back(ivl); q_addr.push_back(a); q_data.push_back(d); q_req.push_back(req);
  endtask

  task automatic exp_seq(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                         input logic [1:0] msel, input bit swap, input bit nodly, input string req);
    int g;
    logic [AW-1:0] la, lb;
    g  = (op != 2'd0 && !nodly) ? CMD_GAP + 1 : 1;
    la = AW'(ua(1'b0, msel, swap));
    lb = AW'(ua(1'b1, msel, swap));
    push_w(-1, la, 8'hAA, req);
    push_w(g, lb, 8'h55, req);
    if (op == 2'd0) begin
      push_w(g, la, 8'hA0, req);
      push_w(g, a, d, req);
    end else begin
      push_w(g, la, 8'h80, req);
      push_w(g, la, 8'hAA, req);
      push_w(g, lb, 8'h55, req);
      case (op)
        2'd1:    push_w(g, a, 8'h30, req);
        2'd2:    push_w(g, a, 8'h50, req);
        default: push_w(g, la, 8'h10, req);
      endcase
    end
  endtask

  task automatic run(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                     input logic [1:0] msel, input bit swap, input bit nodly,
                     input int toggles, input int bad, input int attempts, input bit exp_fail,
                     input string req);
    int start;
    for (int i = 0; i < attempts; i++) exp_seq(op, a, d, msel, swap, nodly, req);
    q_fail.push_back(exp_fail);
    tog_left = toggles; bad_left = bad; cur_data = d; poll_reads = 0; last_we = -1;
    start = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    req_msel = msel; req_swap = swap; req_nodly = nodly;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (done_cnt == start) @(negedge clk);
    chk(q_addr.size() == 0, req, "leftover expected writes", q_addr.size(), 0);
    q_ivl.delete(); q_addr.delete(); q_data.delete(); q_req.delete();
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (fl_we) begin
        if (q_addr.size() == 0) chk(1'b0, "R2", "unexpected write addr", int'(fl_addr), -1);
        else begin
          int ivl; logic [AW-1:0] ea; logic [7:0] ed; string r;
          ivl = q_ivl.pop_front(); ea = q_addr.pop_front(); ed = q_data.pop_front(); r = q_req.pop_front();
          chk(fl_addr == ea, r, "write addr", int'(fl_addr), int'(ea));
          chk(fl_dq_o == ed, r, "write data", int'(fl_dq_o), int'(ed));
          if (ivl > 0) chk(cyc - last_we == ivl, "R6", "write spacing", cyc - last_we, ivl);
        end
        last_we = cyc;
      end
      if (fl_oe) begin
        if (fl_addr == '0) begin
          poll_reads++;
          if (tog_left > 0) begin t6 = ~t6; tog_left--; end
          fl_dq_i = {1'b0, t6, 6'b0};
        end else begin
          fl_dq_i = (bad_left > 0) ? ~cur_data : cur_data;
          if (bad_left > 0) bad_left--;
        end
      end
      if (done) begin
        if (q_fail.size() == 0) chk(1'b0, "R11", "unexpected done", 1, 0);
        else begin
          logic ef; ef = q_fail.pop_front();
          chk(fail == ef, "R11", "fail flag at done", int'(fail), int'(ef));
        end
        done_cnt++;
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
    chk(fl_we == 1'b0 && fl_oe == 1'b0, "R1", "strobes in reset", int'({fl_we, fl_oe}), 0);
    chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);

    // R2 plain program, full mask
    run(2'd0, 20'h12345, 8'h3C, 2'd0, 1'b0, 1'b0, 2, 0, 1, 1'b0, "R2");
    chk(poll_reads == 3, "R7", "program poll reads", poll_reads, 3);
    // R3 R4 swapped, 11-bit mask
    run(2'd0, 20'h00777, 8'h5A, 2'd1, 1'b1, 1'b0, 0, 0, 1, 1'b0, "R3");
    chk(poll_reads == 2, "R7", "poll reads no toggle", poll_reads, 2);
    // R4 R5 R6 sector erase, 12-bit mask, with gaps
    run(2'd1, 20'h40000, 8'h00, 2'd2, 1'b0, 1'b0, 4, 0, 1, 1'b0, "R5");
    chk(poll_reads == 5, "R7", "erase poll reads", poll_reads, 5);
    // R5 R6 block erase, mask select 3, no gaps
    run(2'd2, 20'h80000, 8'h00, 2'd3, 1'b0, 1'b1, 1, 0, 1, 1'b0, "R5");
    // R5 R3 chip erase, swapped
    run(2'd3, 20'h00000, 8'h00, 2'd0, 1'b1, 1'b0, 3, 0, 1, 1'b0, "R5");
    // R10 skip 0xFF
    run(2'd0, 20'h01234, 8'hFF, 2'd0, 1'b0, 1'b0, 0, 0, 0, 1'b0, "R10");
    chk(poll_reads == 0, "R10", "reads on skipped byte", poll_reads, 0);
    // R9 last allowed attempt passes
    run(2'd0, 20'h0ABCD, 8'h81, 2'd0, 1'b0, 1'b0, 1, MAX_TRIES - 1, MAX_TRIES, 1'b0, "R9");
    // R9 all attempts fail
    run(2'd0, 20'h0ABCD, 8'h42, 2'd2, 1'b1, 1'b0, 1, MAX_TRIES, MAX_TRIES, 1'b1, "R9");
    // R8 toggle never settles
    run(2'd3, 20'h00000, 8'h00, 2'd0, 1'b0, 1'b1, 1000, 0, 1, 1'b1, "R8");
    chk(poll_reads == MAX_POLLS + 1, "R8", "reads before poll fail", poll_reads, MAX_POLLS + 1);

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && done_cnt == 9, "R11", "idle after all", done_cnt, 9);
    finish_run();
  end
endmodule